// File: doc/BRIEF.md
# Two-Pass Big-Integer Multiply-Subtract Row

This block subtracts the product of a multi-limb unsigned vector and a single quotient word from a multi-limb minuend. It is the inner step of schoolbook long division. The work runs in two sequential passes, with one limb handled per clock in each pass.

In the first pass, each minuend limb is zero-extended to double width, and the product of its multiplier limb and the quotient word is subtracted from it. The difference is split into a low limb and a high limb. The low limb goes to slot `i` of an internal register vector. The high limb goes to slot `VL+i`, so the second vector sits at an offset equal to the vector length.

In the second pass, each high/low pair is joined again and the running borrow, sign-extended, is subtracted from it. The low half is written out as the result limb. The upper half is negated and becomes the borrow for the next element. When the last element is done, the block pulses `done_o`. In that same cycle it raises `fixup_o` if the final borrow is nonzero, which tells the caller that the quotient guess needs an add-back correction.

A caller normally drives `borrow_i` with zero. The whole operation is then three steps: clear the borrow, multiply-subtract, propagate the borrow.

Top module: `bigint_mulsub_row`

## Requirements
- R1: After a synchronous active-low reset, `done_o` and `fixup_o` are low, and `borrow_o` and every limb of `diff_o` are zero.
- R2: Let `W` be the limb width, `i` the element index (0 to VL-1) and `k` the current borrow. Each element forms `v = zext(c[i]) - a[i]*q - sext(k)` modulo 2^(2W). Result limb `i` is `v[W-1:0]`. Limb `i` sits at bit offset `i*W` of `c_limbs_i`, `a_limbs_i` and `diff_o`.
- R3: The borrow for element `i+1` is the two's-complement negation, modulo 2^W, of `v[2W-1:W]` from element `i`.
- R4: The borrow for element 0 is `borrow_i`, captured in the cycle `start_i` is accepted. `q_word_i` is captured in the same cycle. Changing either one later has no effect on the running operation.
- R5: After completion, `borrow_o` holds the borrow left by the last element. It keeps that value until the next accepted start.
- R6: `fixup_o` is high only in the `done_o` cycle, and only when the final borrow is nonzero.
- R7: `done_o` is a one-cycle pulse that becomes visible 2*VL clock edges after the edge that accepts `start_i`.
- R8: Elements are processed from index 0 upward. After completion, every `diff_o` limb at an index of VL or above reads zero.
- R9: A `vl_i` of 0 is treated as 1. A `vl_i` above `MAXVL` is treated as `MAXVL`.
- R10: `start_i` is accepted only while the block is idle. A start raised during an operation is ignored and does not change its result. A start raised in the `done_o` cycle begins a new operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin an operation when idle |
| vl_i | input | $clog2(MAXVL+1) | Requested vector length |
| c_limbs_i | input | MAXVL*W | Minuend limbs; must hold through pass one |
| a_limbs_i | input | MAXVL*W | Multiplier limbs; must hold through pass one |
| q_word_i | input | W | Scalar quotient word |
| borrow_i | input | W | Initial borrow (normally zero) |
| diff_o | output | MAXVL*W | Result limbs |
| borrow_o | output | W | Final borrow |
| done_o | output | 1 | Completion pulse |
| fixup_o | output | 1 | Final borrow nonzero, valid with done |

## Verification
The write-back of the final limb and borrow coincides with the `done_o` and `fixup_o` pulse. The bench samples all of them in that cycle and compares them against a bench-side model of the limb arithmetic.

The clearing and capture for a new start can also fall in the `done_o` cycle. The bench provokes this by raising `start_i` with fresh operands in the same cycle it judges a completion. It then checks that the first result was read intact and that the chained operation completes with its own correct result and latency.

A start raised in mid-operation, together with changed `q_word_i` and `borrow_i`, is judged by comparing the result against the values captured at the original start.

// File: rtl/bigsub_pkg.sv
// Package: shared types for the two-pass multiply-subtract row.
package bigsub_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_MUL  = 2'd1,
        PH_PROP = 2'd2
    } phase_t;
endpackage

// File: rtl/bigsub_mul_lane.sv
// Pass-one arithmetic: zero-extended minuend limb minus a limb-by-word
// product, at double width and modulo 2^(2W), split into low and high halves.
// Purely combinational; assumes unsigned limbs.
module bigsub_mul_lane #(
    parameter int W = 64
) (
    input  logic [W-1:0] c_limb,
    input  logic [W-1:0] a_limb,
    input  logic [W-1:0] q_word,
    output logic [W-1:0] lo_half,
    output logic [W-1:0] hi_half
);
    logic [2*W-1:0] prod;
    logic [2*W-1:0] dif;

    // Double-width product and difference.
    always_comb begin
        prod = {{W{1'b0}}, a_limb} * {{W{1'b0}}, q_word};
        dif  = {{W{1'b0}}, c_limb} - prod;
        lo_half = dif[W-1:0];
        hi_half = dif[2*W-1:W];
    end
endmodule

// File: rtl/bigsub_prop_lane.sv
// Pass-two arithmetic: joins a high/low pair, subtracts the sign-extended
// borrow, returns the low limb and the next borrow (negated upper half).
// Purely combinational.
module bigsub_prop_lane #(
    parameter int W = 64
) (
    input  logic [W-1:0] hi_half,
    input  logic [W-1:0] lo_half,
    input  logic [W-1:0] borrow_in,
    output logic [W-1:0] limb_out,
    output logic [W-1:0] borrow_next
);
    logic [2*W-1:0] joined;

    // Recombine, subtract the borrow and negate the upper half.
    always_comb begin
        joined      = {hi_half, lo_half} - {{W{borrow_in[W-1]}}, borrow_in};
        limb_out    = joined[W-1:0];
        borrow_next = ~joined[2*W-1:W] + {{(W-1){1'b0}}, 1'b1};
    end
endmodule

// File: rtl/bigsub_seq_ctrl.sv
// Sequencer: accepts a start when idle, clamps the vector length, walks the
// element index through pass one and then pass two, and pulses done.
// Assumes MAXVL >= 1.
module bigsub_seq_ctrl
    import bigsub_pkg::*;
#(
    parameter  int MAXVL = 8,
    localparam int VLW   = $clog2(MAXVL + 1),
    localparam int IW    = (MAXVL > 1) ? $clog2(MAXVL) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [VLW-1:0] vl_req,
    output phase_t         phase,
    output logic [IW-1:0]  idx,
    output logic [VLW-1:0] vl_eff,
    output logic           accept,
    output logic           last,
    output logic           done
);
    logic [VLW-1:0] vl_clamped;

    // Clamp the requested length into 1..MAXVL.
    always_comb begin
        if (vl_req == '0)
            vl_clamped = VLW'(1);
        else if (vl_req > VLW'(MAXVL))
            vl_clamped = VLW'(MAXVL);
        else
            vl_clamped = vl_req;
    end

    assign accept = (phase == PH_IDLE) && start;
    assign last   = (VLW'(idx) == (vl_eff - VLW'(1)));

    // Phase and index sequencing with a one-cycle done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            idx    <= '0;
            vl_eff <= VLW'(1);
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        vl_eff <= vl_clamped;
                        idx    <= '0;
                        phase  <= PH_MUL;
                    end
                end
                PH_MUL: begin
                    if (last) begin
                        idx   <= '0;
                        phase <= PH_PROP;
                    end else begin
                        idx <= idx + IW'(1);
                    end
                end
                PH_PROP: begin
                    if (last) begin
                        idx   <= '0;
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                    end else begin
                        idx <= idx + IW'(1);
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bigint_mulsub_row.sv
// Top: big-integer row multiply-subtract in two passes over a register
// vector of 2*MAXVL limbs. Pass one fills slot i (low) and slot VL+i (high);
// pass two folds the borrow through them from element 0 upward.
// Assumes c_limbs_i and a_limbs_i hold steady until pass one ends.
module bigint_mulsub_row
    import bigsub_pkg::*;
#(
    parameter  int W     = 64,
    parameter  int MAXVL = 8,
    localparam int VLW   = $clog2(MAXVL + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [VLW-1:0]     vl_i,
    input  logic [MAXVL*W-1:0] c_limbs_i,
    input  logic [MAXVL*W-1:0] a_limbs_i,
    input  logic [W-1:0]       q_word_i,
    input  logic [W-1:0]       borrow_i,
    output logic [MAXVL*W-1:0] diff_o,
    output logic [W-1:0]       borrow_o,
    output logic               done_o,
    output logic               fixup_o
);
    localparam int IW = (MAXVL > 1) ? $clog2(MAXVL) : 1;
    localparam int SW = $clog2(2 * MAXVL);

    phase_t         phase;
    logic [IW-1:0]  idx;
    logic [VLW-1:0] vl_eff;
    logic           accept;
    logic           last;

    logic [W-1:0] rf      [2*MAXVL];
    logic [W-1:0] diff_q  [MAXVL];
    logic [W-1:0] q_q;
    logic [W-1:0] k_q;
    logic         fixup_q;

    logic [SW-1:0] lo_addr;
    logic [SW-1:0] hi_addr;
    logic [W-1:0]  p1_lo, p1_hi, p2_limb, p2_knext;

    bigsub_seq_ctrl #(.MAXVL(MAXVL)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start_i),
        .vl_req (vl_i),
        .phase  (phase),
        .idx    (idx),
        .vl_eff (vl_eff),
        .accept (accept),
        .last   (last),
        .done   (done_o)
    );

    // Slot addresses: low at i, high at VL+i.
    assign lo_addr = SW'(idx);
    assign hi_addr = SW'(vl_eff) + SW'(idx);

    bigsub_mul_lane #(.W(W)) u_mul (
        .c_limb  (c_limbs_i[int'(idx)*W +: W]),
        .a_limb  (a_limbs_i[int'(idx)*W +: W]),
        .q_word  (q_q),
        .lo_half (p1_lo),
        .hi_half (p1_hi)
    );

    bigsub_prop_lane #(.W(W)) u_prop (
        .hi_half     (rf[hi_addr]),
        .lo_half     (rf[lo_addr]),
        .borrow_in   (k_q),
        .limb_out    (p2_limb),
        .borrow_next (p2_knext)
    );

    // Operand capture, pass-one writes, pass-two write-back and borrow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < 2 * MAXVL; s++) rf[s] <= '0;
            for (int e = 0; e < MAXVL; e++) diff_q[e] <= '0;
            q_q     <= '0;
            k_q     <= '0;
            fixup_q <= 1'b0;
        end else begin
            fixup_q <= 1'b0;
            if (accept) begin
                q_q <= q_word_i;
                k_q <= borrow_i;
                for (int e = 0; e < MAXVL; e++) diff_q[e] <= '0;
            end
            if (phase == PH_MUL) begin
                rf[lo_addr] <= p1_lo;
                rf[hi_addr] <= p1_hi;
            end
            if (phase == PH_PROP) begin
                diff_q[idx] <= p2_limb;
                k_q         <= p2_knext;
                if (last) fixup_q <= (p2_knext != '0);
            end
        end
    end

    // Flatten result limbs onto the output bus.
    for (genvar g = 0; g < MAXVL; g++) begin : g_out
        assign diff_o[g*W +: W] = diff_q[g];
    end

    assign borrow_o = k_q;
    assign fixup_o  = fixup_q;
endmodule

// File: rtl/bigint_mulsub_row_chk.sv
// Checker: temporal properties of the row multiply-subtract, bound to the top.
module bigint_mulsub_row_chk
    import bigsub_pkg::*;
#(
    parameter  int W     = 64,
    parameter  int MAXVL = 8,
    localparam int VLW   = $clog2(MAXVL + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start_i,
    input logic [W-1:0]   borrow_o,
    input logic           done_o,
    input logic           fixup_o,
    input phase_t         phase,
    input logic [VLW-1:0] vl_eff
);
    logic [7:0] busy_cnt;

    // Count busy cycles of the current operation.
    always_ff @(posedge clk) begin
        if (!rst_n)                busy_cnt <= '0;
        else if (phase == PH_IDLE) busy_cnt <= '0;
        else                       busy_cnt <= busy_cnt + 8'd1;
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (busy_cnt == 8'(2 * vl_eff)));

    // R6
    fixup_only_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fixup_o |-> done_o);

    // R6
    fixup_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (fixup_o == (borrow_o != '0)));

    // R10
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE && start_i) |=> $stable(vl_eff));

    // R9
    vl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vl_eff >= VLW'(1)) && (vl_eff <= VLW'(MAXVL)));

    // R5
    borrow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && !start_i) |=> $stable(borrow_o));
endmodule

bind bigint_mulsub_row bigint_mulsub_row_chk #(.W(W), .MAXVL(MAXVL)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .borrow_o (borrow_o),
    .done_o   (done_o),
    .fixup_o  (fixup_o),
    .phase    (phase),
    .vl_eff   (vl_eff)
);

// File: tb/bigint_mulsub_row_tb.sv
`timescale 1ns/1ps
module bigint_mulsub_row_tb;
    localparam int W     = 64;
    localparam int MAXVL = 8;
    localparam int VLW   = $clog2(MAXVL + 1);

    logic               clk = 1'b0;
    logic               rst_n;
    logic               start_i;
    logic [VLW-1:0]     vl_i;
    logic [MAXVL*W-1:0] c_limbs_i, a_limbs_i;
    logic [W-1:0]       q_word_i, borrow_i;
    logic [MAXVL*W-1:0] diff_o;
    logic [W-1:0]       borrow_o;
    logic               done_o, fixup_o;

    int checks = 0;
    int errors = 0;

    logic [W-1:0] exp_diff [MAXVL];
    logic [W-1:0] exp_k;
    int           exp_vl;

    always #2.5 clk = ~clk;

    bigint_mulsub_row #(.W(W), .MAXVL(MAXVL)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .vl_i(vl_i),
        .c_limbs_i(c_limbs_i), .a_limbs_i(a_limbs_i), .q_word_i(q_word_i),
        .borrow_i(borrow_i), .diff_o(diff_o), .borrow_o(borrow_o),
        .done_o(done_o), .fixup_o(fixup_o)
    );

    task automatic check(input bit ok, input string req,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Bench model of the requirements R2, R3, R4, R9.
    task automatic model();
        logic [2*W-1:0] v;
        logic [W-1:0]   k;
        exp_vl = (vl_i == 0) ? 1 : ((int'(vl_i) > MAXVL) ? MAXVL : int'(vl_i));
        k = borrow_i;
        for (int i = 0; i < MAXVL; i++) exp_diff[i] = '0;
        for (int i = 0; i < exp_vl; i++) begin
            v = {{W{1'b0}}, c_limbs_i[i*W +: W]}
              - ({{W{1'b0}}, a_limbs_i[i*W +: W]} * {{W{1'b0}}, q_word_i})
              - {{W{k[W-1]}}, k};
            exp_diff[i] = v[W-1:0];
            k = -v[2*W-1:W];
        end
        exp_k = k;
    endtask

    task automatic rand_ops(input int vl);
        vl_i = VLW'(vl);
        for (int i = 0; i < MAXVL; i++) begin
            c_limbs_i[i*W +: W] = {$urandom, $urandom};
            a_limbs_i[i*W +: W] = {$urandom, $urandom};
        end
        q_word_i = {$urandom, $urandom};
        borrow_i = '0;
    endtask

    // Waits for done with start already raised; poke: start again mid-run;
    // chain: raise a new start with fresh random operands in the done cycle.
    task automatic finish(input bit poke, input bit chain, input int chain_vl);
        int cnt = 0;
        model();
        do begin
            @(negedge clk);
            cnt++;
            if (cnt == 1) start_i = 1'b0;
            if (poke && cnt == 3) begin
                start_i  = 1'b1;
                q_word_i = ~q_word_i;
                borrow_i = borrow_i + 64'd5;
            end
            if (poke && cnt == 4) start_i = 1'b0;
        end while (!done_o && cnt < 100);
        check(done_o && cnt == 2 * exp_vl + 1, "R7 latency",
              W'(cnt), W'(2 * exp_vl + 1));
        for (int i = 0; i < MAXVL; i++) begin
            if (i < exp_vl)
                check(diff_o[i*W +: W] === exp_diff[i], poke ? "R10 limb" : "R2 limb",
                      diff_o[i*W +: W], exp_diff[i]);
            else
                check(diff_o[i*W +: W] === '0, "R8 upper limb",
                      diff_o[i*W +: W], '0);
        end
        check(borrow_o === exp_k, "R3 final borrow", borrow_o, exp_k);
        check(fixup_o === (exp_k != '0), "R6 fixup", W'(fixup_o), W'(exp_k != '0));
        if (chain) begin
            rand_ops(chain_vl);
            start_i = 1'b1;
        end else begin
            @(negedge clk);
            check(!done_o && !fixup_o, "R7 pulse ends", W'({done_o, fixup_o}), '0);
            repeat (2) @(negedge clk);
            check(borrow_o === exp_k, "R5 borrow held", borrow_o, exp_k);
        end
    endtask

    task automatic go(input bit poke);
        start_i = 1'b1;
        finish(poke, 1'b0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0; start_i = 1'b0; vl_i = '0;
        c_limbs_i = '0; a_limbs_i = '0; q_word_i = '0; borrow_i = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!done_o && !fixup_o, "R1 flags", W'({done_o, fixup_o}), '0);
        check(borrow_o === '0, "R1 borrow", borrow_o, '0);
        check(diff_o === '0, "R1 diff", diff_o[W-1:0], '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 zero quotient word: result equals minuend, no fixup
        rand_ops(4); q_word_i = '0; go(1'b0);
        // R2 R3 all-ones operands, full length
        rand_ops(8);
        c_limbs_i = '1; a_limbs_i = '1; q_word_i = '1; go(1'b0);
        // R4 nonzero initial borrow with top bit set (sign extension)
        rand_ops(5); borrow_i = 64'h8000_0000_0000_0003; go(1'b0);
        rand_ops(3); borrow_i = 64'd7; go(1'b0);
        // R9 length clamping
        rand_ops(0); go(1'b0);
        rand_ops(12); go(1'b0);
        // R6 small product with zero borrow-in leaves no borrow
        rand_ops(2); q_word_i = 64'd1;
        a_limbs_i = '0; go(1'b0);
        // R10 start during operation is ignored
        rand_ops(6); go(1'b1);
        // R10 back-to-back start in the done cycle
        rand_ops(3); start_i = 1'b1;
        finish(1'b0, 1'b1, 7);
        finish(1'b0, 1'b0, 0);
        // Random operations
        for (int n = 0; n < 20; n++) begin
            rand_ops(1 + ($urandom % 8));
            if (n % 4 == 0) borrow_i = {32'd0, $urandom};
            go(1'b0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule